// File: doc/BRIEF.md
# Software Serial-Flash Pin Control Register

This block is a 32-bit control register through which host software drives a serial flash device by hand. Each write sets or clears the serial clock, the chip select and the data line going to the flash. Software toggles the clock bit over successive writes to shift out commands, addresses and data. The data line coming back from the flash is synchronized to the core clock and can be read in the same register.

The flash pins normally belong to an internal flash engine. Software must first set a request bit. A grant bit reports when it may drive the pins, and the pins switch over only while the grant is held. Clearing the request hands the pins back to the engine.

The register also has a self-clearing erase trigger, which fires only when an external two-bit mode field reads zero. A busy flag stays set from the erase until the engine reports that the command is done. The register resets only from the power-on reset or the power-good reset. A software reset does not reach it.

Top module: `flash_bitbang_reg`

## Requirements
- R1: Bit 0 (serial clock), bit 1 (chip select, active low at the pin) and bit 2 (data to flash) read back the value last written, one clock edge after the write.
- R2: Bits 29:6 and bit 31 always read as 0, whatever value is written to them.
- R3: While grant (bit 5) is 1, `flash_sck`, `flash_cs_n` and `flash_si` equal register bits 0, 1 and 2. While grant is 0, they follow the engine inputs `eng_sck`, `eng_cs_n` and `eng_si`.
- R4: Request (bit 4) reads back the value written. Grant rises on the clock edge after request reads 1, but only while `eng_active` is 0. While the engine is active, a pending request is not granted.
- R5: After request is written to 0, grant reads 1 for one more cycle and then drops to 0, returning the pins to the engine.
- R6: Bit 3 shows `flash_so` after a two-flop synchronizer and a latch, so a level change appears on the third clock edge.
- R7: Writing 1 to bit 31 while `erase_mode` is 00 and busy is 0 raises `erase_start` for exactly one cycle and sets busy (bit 30) on the same edge.
- R8: Writing 1 to bit 31 while `erase_mode` is not 00 starts no erase: `erase_start` stays 0 and busy stays 0.
- R9: Busy stays 1 until an `eng_done` pulse clears it. An erase written while busy is 1 produces no `erase_start`.
- R10: Driving either `por_n` or `pg_n` low clears the whole register to 0: no request, no grant, busy clear, and the pins with the engine.
- R11: Writes to bit 3 (data from flash), bit 5 (grant) and bit 30 (busy) have no effect on those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pg_n | input | 1 | Power-good reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| erase_mode | input | 2 | Mode field that qualifies the erase trigger |
| eng_active | input | 1 | Internal engine is using the flash pins |
| eng_done | input | 1 | Engine pulse that ends a write or erase |
| eng_sck | input | 1 | Engine serial clock |
| eng_cs_n | input | 1 | Engine chip select, active low |
| eng_si | input | 1 | Engine data to flash |
| erase_start | output | 1 | One-cycle erase launch to the engine |
| flash_so | input | 1 | Data from flash, asynchronous |
| flash_sck | output | 1 | Serial clock pin |
| flash_cs_n | output | 1 | Chip select pin, active low |
| flash_si | output | 1 | Data pin to flash |

## Verification
Each result has a fixed delay after the write that causes it. The control bits, busy and `erase_start` are due one edge after the write. Grant is due one edge after request changes, so two edges after the write. Bit 3 is due three edges after a change on `flash_so`. The bench drives every input on a falling edge and samples only on a falling edge. It counts the rising edges in between, checks just before a result is due to confirm it has not changed yet, and checks again when it is due. For example, it confirms that grant still reads 1 one cycle after the request is cleared.

// File: rtl/flash_bitbang_reg.sv
module flash_bitbang_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        pg_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [1:0]  erase_mode,
  input  logic        eng_active,
  input  logic        eng_done,
  input  logic        eng_sck,
  input  logic        eng_cs_n,
  input  logic        eng_si,
  output logic        erase_start,
  input  logic        flash_so,
  output logic        flash_sck,
  output logic        flash_cs_n,
  output logic        flash_si
);

  localparam int SCK_B = 0, CS_B = 1, SI_B = 2, SO_B = 3;
  localparam int REQ_B = 4, GNT_B = 5, BUSY_B = 30, ERASE_B = 31;

  logic                   rst_n;
  logic                   sck_q, cs_q, si_q, req_q, grant_q, busy_q, so_q;
  logic [SYNC_STAGES-1:0] so_sync;
  logic                   erase_hit;

  assign rst_n = por_n & pg_n;

  assign erase_hit = wr_en && wr_data[ERASE_B] && (erase_mode == 2'b00) && !busy_q;

  always_ff @(posedge clk or negedge por_n or negedge pg_n) begin
    if (!por_n || !pg_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
      si_q  <= 1'b0;
      req_q <= 1'b0;
    end else if (wr_en) begin
      sck_q <= wr_data[SCK_B];
      cs_q  <= wr_data[CS_B];
      si_q  <= wr_data[SI_B];
      req_q <= wr_data[REQ_B];
    end
  end

  always_ff @(posedge clk or negedge por_n or negedge pg_n) begin
    if (!por_n || !pg_n) grant_q <= 1'b0;
    else                 grant_q <= req_q && (grant_q || !eng_active);
  end

  always_ff @(posedge clk or negedge por_n or negedge pg_n) begin
    if (!por_n || !pg_n) begin
      busy_q      <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      erase_start <= erase_hit;
      if (erase_hit)     busy_q <= 1'b1;
      else if (eng_done) busy_q <= 1'b0;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge por_n or negedge pg_n) begin
        if (!por_n || !pg_n) so_sync <= '0;
        else                 so_sync <= flash_so;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge por_n or negedge pg_n) begin
        if (!por_n || !pg_n) so_sync <= '0;
        else                 so_sync <= {so_sync[SYNC_STAGES-2:0], flash_so};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n or negedge pg_n) begin
    if (!por_n || !pg_n) so_q <= 1'b0;
    else                 so_q <= so_sync[SYNC_STAGES-1];
  end

  assign flash_sck  = grant_q ? sck_q : eng_sck;
  assign flash_cs_n = grant_q ? cs_q  : eng_cs_n;
  assign flash_si   = grant_q ? si_q  : eng_si;

  always_comb begin
    rd_data          = '0;
    rd_data[SCK_B]   = sck_q;
    rd_data[CS_B]    = cs_q;
    rd_data[SI_B]    = si_q;
    rd_data[SO_B]    = so_q;
    rd_data[REQ_B]   = req_q;
    rd_data[GNT_B]   = grant_q;
    rd_data[BUSY_B]  = busy_q;
  end

  assert_grant_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_q) |-> ($past(req_q) && !$past(eng_active)));

  assert_grant_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q && !req_q) |=> !grant_q);

  assert_erase_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  assert_erase_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> busy_q);

  assert_erase_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(wr_en) && $past(wr_data[ERASE_B]) && ($past(erase_mode) == 2'b00)));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eng_done) |=> busy_q);

  assert_no_erase_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(busy_q));

endmodule

// File: tb/test_flash_bitbang_reg.sv
module test_flash_bitbang_reg;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, pg_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  erase_mode = 2'b01;
  logic        eng_active = 1'b0, eng_done = 1'b0;
  logic        eng_sck = 1'b0, eng_cs_n = 1'b1, eng_si = 1'b0;
  logic        erase_start, flash_so = 1'b0;
  logic        flash_sck, flash_cs_n, flash_si;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_bitbang_reg i_flash_bitbang_reg (
    .clk(clk), .por_n(por_n), .pg_n(pg_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .erase_mode(erase_mode), .eng_active(eng_active),
    .eng_done(eng_done), .eng_sck(eng_sck), .eng_cs_n(eng_cs_n), .eng_si(eng_si),
    .erase_start(erase_start), .flash_so(flash_so), .flash_sck(flash_sck),
    .flash_cs_n(flash_cs_n), .flash_si(flash_si));

  // write value, expected read value two edges later (grant settled)
  localparam logic [63:0] VECS [8] = '{
    {32'hFFFF_FFFF, 32'h0000_0037},
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0015, 32'h0000_0035},
    {32'h0000_000A, 32'h0000_0002},
    {32'h7FFF_FFC0, 32'h0000_0000},
    {32'h0000_0010, 32'h0000_0030},
    {32'h0000_0027, 32'h0000_0007},
    {32'h8000_0001, 32'h0000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [2:0] exp_pins(input logic [31:0] r);
    return r[5] ? {r[0], r[1], r[2]} : {eng_sck, eng_cs_n, eng_si};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R10 reset value", rd_data, 32'h0);
    chk("R3 pins after reset", {29'h0, flash_sck, flash_cs_n, flash_si}, {29'h0, 3'b010});

    foreach (VECS[i]) begin
      wr(VECS[i][63:32]);
      @(negedge clk);
      chk("R1 R2 R4 R11 table readback", rd_data, VECS[i][31:0]);
      chk("R3 table pins", {29'h0, flash_sck, flash_cs_n, flash_si},
          {29'h0, exp_pins(VECS[i][31:0])});
      chk("R7 R8 no erase in table", {31'h0, erase_start}, 32'h0);
    end

    // R4: engine active blocks grant
    wr(32'h0);
    @(negedge clk);
    eng_active = 1'b1;
    wr(32'h0000_0011);
    repeat (3) @(negedge clk);
    chk("R4 no grant while engine active", rd_data, 32'h0000_0011);
    chk("R3 engine keeps pins", {29'h0, flash_sck, flash_cs_n, flash_si}, {29'h0, 3'b010});
    eng_active = 1'b0;
    @(negedge clk);
    chk("R4 grant after engine idle", rd_data, 32'h0000_0031);
    chk("R3 software drives pins", {29'h0, flash_sck, flash_cs_n, flash_si}, {29'h0, 3'b100});

    // R5: grant drops one cycle after request cleared
    wr(32'h0000_0001);
    chk("R5 grant held one cycle", rd_data, 32'h0000_0021);
    @(negedge clk);
    chk("R5 grant dropped", rd_data, 32'h0000_0001);
    chk("R5 pins back to engine", {29'h0, flash_sck, flash_cs_n, flash_si}, {29'h0, 3'b010});

    // R6: data-out latency
    wr(32'h0);
    @(negedge clk); flash_so = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 data-out not yet visible", {31'h0, rd_data[3]}, 32'h0);
    @(negedge clk);
    chk("R6 data-out after three edges", {31'h0, rd_data[3]}, 32'h1);
    wr(32'h0000_0000);
    chk("R11 write to bit 3 ignored", {31'h0, rd_data[3]}, 32'h1);
    flash_so = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 data-out falls", {31'h0, rd_data[3]}, 32'h0);

    // R8: mode not 00
    erase_mode = 2'b10;
    wr(32'h8000_0000);
    chk("R8 no erase pulse", {31'h0, erase_start}, 32'h0);
    chk("R8 busy stays clear", rd_data, 32'h0);

    // R7: qualified erase
    erase_mode = 2'b00;
    wr(32'h8000_0000);
    chk("R7 erase pulse", {31'h0, erase_start}, 32'h1);
    chk("R7 busy set R2 erase bit reads 0", rd_data, 32'h4000_0000);
    @(negedge clk);
    chk("R7 erase pulse one cycle", {31'h0, erase_start}, 32'h0);

    // R9: erase while busy ignored, done clears
    wr(32'h8000_0000);
    chk("R9 no erase while busy", {31'h0, erase_start}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 busy held", rd_data, 32'h4000_0000);
    eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    chk("R9 busy cleared by done", rd_data, 32'h0);
    erase_mode = 2'b01;

    // R11: busy and grant not writable
    wr(32'h4000_0020);
    @(negedge clk);
    chk("R11 busy and grant unwritable", rd_data, 32'h0);

    // R10: power-good reset
    wr(32'h0000_0017);
    @(negedge clk);
    chk("R10 setup before reset", rd_data, 32'h0000_0037);
    pg_n = 1'b0;
    #1;
    chk("R10 power-good reset clears", rd_data, 32'h0);
    chk("R10 pins to engine", {29'h0, flash_sck, flash_cs_n, flash_si}, {29'h0, 3'b010});
    @(negedge clk); pg_n = 1'b1;
    wr(32'h0000_0017);
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R10 power-on reset clears", rd_data, 32'h0);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    chk("R10 stays clear after reset", rd_data, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule